// File: doc/BRIEF.md
# Firmware Glue Register Block

This block is a small memory-mapped slave that gathers the odd registers boot firmware relies on during bring-up. Through one register bus it lets a processor halt the system with an exit code, ask which processor it is and how many are present, raise or drop a level on any processor's interrupt line, and exchange single bytes with a console in both directions.

Each bus request is accepted in the cycle it is presented and answered exactly one cycle later. Only the low six address bits take part in decode, so the register set repeats every 64 bytes. The console input holds at most one byte. It stops accepting new bytes until software consumes the held byte or clears the status. The console output has no back-pressure: every store to the output data register emits one byte on the output stream at once.

Top module: `fw_glue_regs`

## Requirements
- R1: The decode uses only address bits [5:0]. Any higher address bits have no effect, so the registers alias every 64 bytes.
- R2: A write to offset 0x00 sets `halt_o` one cycle later and latches write byte 0 (`req_wdata_i[7:0]`) on `exit_code_o`. `halt_o` stays high until reset. A later write to 0x00 replaces the exit code.
- R3: A read of offset 0x04 returns `req_cpu_i`, zero-extended, in `rsp_rdata_o[7:0]`.
- R4: A read of offset 0x0C returns the configured processor count `CPU_COUNT`, or 1 when `CPU_COUNT` is 0.
- R5: A write to offset 0x08 with `req_bytes_i` of 2 or more takes the line index from byte 0 (`req_wdata_i[7:0]`) and the level from byte 1 (`req_wdata_i[15:8]`). The selected `irq_o` bit becomes 1 when that level is nonzero and 0 when it is zero. Every line holds its value until a later write selects it.
- R6: An interrupt write with `req_bytes_i` equal to 1 drives level 0 on the selected line. An interrupt write whose index is `NUM_CPU` or more changes no line.
- R7: `rx_ready_o` is high exactly when the input status (offset 0x14) is zero. A byte offered with `rx_valid_i` while ready is stored, and the status becomes 1. Offset 0x10 reads back the stored byte, and that read sets the status to 0, unless a new byte is taken in the same cycle. A byte offered while not ready is dropped.
- R8: A write to offset 0x18 pulses `tx_valid_o` for one cycle, one cycle later, with `tx_data_o` equal to write byte 0. The same write stores the byte for readback at 0x18 and sets the output status at 0x1C to 1.
- R9: After reset the output status is 1, the input status is 0, both data bytes are 0, all `irq_o` lines are 0, and `halt_o`, `rsp_valid_o` and `tx_valid_o` are 0.
- R10: Writes to offsets 0x10, 0x14 and 0x1C store write byte 0 directly into the input data, input status and output status. Such a write takes precedence over a console byte taken in the same cycle.
- R11: Reads of any offset not listed above, and of the write-only offsets 0x00 and 0x08, return 0 and have no side effect. Writes to unlisted offsets and to the read-only offsets 0x04 and 0x0C change nothing.
- R12: `rsp_valid_o` is high exactly one cycle after `req_valid_i`. `rsp_rdata_o` carries the read byte in bits [7:0], and all other bits are 0. For writes and idle cycles the whole of `rsp_rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Bus request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address; bits [5:0] decoded |
| req_bytes_i | input | 3 | Number of bytes in the access (1 to 4) |
| req_wdata_i | input | DATA_W | Write data; byte 0 in bits [7:0] |
| req_cpu_i | input | CPU_W | Index of the requesting processor |
| rsp_valid_o | output | 1 | Response for the previous cycle's request |
| rsp_rdata_o | output | DATA_W | Read data, zero-extended byte |
| rx_valid_i | input | 1 | Console input byte offered |
| rx_data_i | input | 8 | Console input byte |
| rx_ready_o | output | 1 | Input buffer can take a byte |
| tx_valid_o | output | 1 | Console output byte pulse |
| tx_data_o | output | 8 | Console output byte |
| irq_o | output | NUM_CPU | One interrupt level per processor |
| halt_o | output | 1 | Halt request, sticky until reset |
| exit_code_o | output | 8 | Latched exit status |

## Verification
A wrong bit in the console buffer state has two visible effects. It shows on the very next read of 0x10, 0x14, 0x18 or 0x1C. It also shows at once on `rx_ready_o`, which mirrors the input status every cycle. A corrupted interrupt line appears on `irq_o` one cycle after the write that caused it, and it persists, so the check after any later operation also catches it. Faults in decode or in the response path show in the `rsp_rdata_o` value of the same transaction, one cycle after the request.

// File: rtl/fwg_pkg.sv
package fwg_pkg;

    localparam int OFS_W = 6;

    localparam logic [OFS_W-1:0] OFS_HALT    = 6'h00;
    localparam logic [OFS_W-1:0] OFS_CPU_ID  = 6'h04;
    localparam logic [OFS_W-1:0] OFS_IRQ     = 6'h08;
    localparam logic [OFS_W-1:0] OFS_CPU_CNT = 6'h0C;
    localparam logic [OFS_W-1:0] OFS_RX_DATA = 6'h10;
    localparam logic [OFS_W-1:0] OFS_RX_STAT = 6'h14;
    localparam logic [OFS_W-1:0] OFS_TX_DATA = 6'h18;
    localparam logic [OFS_W-1:0] OFS_TX_STAT = 6'h1C;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_HALT,
        SEL_CPU_ID,
        SEL_IRQ,
        SEL_CPU_CNT,
        SEL_RX_DATA,
        SEL_RX_STAT,
        SEL_TX_DATA,
        SEL_TX_STAT
    } reg_sel_e;

    typedef struct packed {
        logic [7:0] rx_data;
        logic [7:0] rx_stat;
        logic [7:0] tx_data;
        logic [7:0] tx_stat;
        logic       tx_pulse;
    } con_state_t;

endpackage

// File: rtl/fwg_decode.sv
module fwg_decode
    import fwg_pkg::*;
(
    input  logic [OFS_W-1:0] ofs_i,
    output reg_sel_e         sel_o
);

    always_comb begin
        unique case (ofs_i)
            OFS_HALT:    sel_o = SEL_HALT;
            OFS_CPU_ID:  sel_o = SEL_CPU_ID;
            OFS_IRQ:     sel_o = SEL_IRQ;
            OFS_CPU_CNT: sel_o = SEL_CPU_CNT;
            OFS_RX_DATA: sel_o = SEL_RX_DATA;
            OFS_RX_STAT: sel_o = SEL_RX_STAT;
            OFS_TX_DATA: sel_o = SEL_TX_DATA;
            OFS_TX_STAT: sel_o = SEL_TX_STAT;
            default:     sel_o = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/fwg_console.sv
module fwg_console
    import fwg_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       acc_i,
    input  logic       we_i,
    input  reg_sel_e   sel_i,
    input  logic [7:0] wbyte_i,
    input  logic       rx_valid_i,
    input  logic [7:0] rx_data_i,
    output logic       rx_ready_o,
    output logic       tx_valid_o,
    output logic [7:0] tx_data_o,
    output logic [7:0] rx_data_q_o,
    output logic [7:0] rx_stat_o,
    output logic [7:0] tx_data_q_o,
    output logic [7:0] tx_stat_o
);

    con_state_t s_d, s_q;
    logic       take_d;
    logic       consume_d;

    always_comb begin
        s_d          = s_q;
        s_d.tx_pulse = 1'b0;
        take_d       = rx_valid_i && (s_q.rx_stat == 8'd0);
        consume_d    = acc_i && !we_i && (sel_i == SEL_RX_DATA);

        if (take_d) begin
            s_d.rx_data = rx_data_i;
            s_d.rx_stat = 8'd1;
        end else if (consume_d) begin
            s_d.rx_stat = 8'd0;
        end

        if (acc_i && we_i) begin
            case (sel_i)
                SEL_RX_DATA: s_d.rx_data = wbyte_i;
                SEL_RX_STAT: s_d.rx_stat = wbyte_i;
                SEL_TX_DATA: begin
                    s_d.tx_data  = wbyte_i;
                    s_d.tx_stat  = 8'd1;
                    s_d.tx_pulse = 1'b1;
                end
                SEL_TX_STAT: s_d.tx_stat = wbyte_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q         <= '0;
            s_q.tx_stat <= 8'd1;
        end else begin
            s_q <= s_d;
        end
    end

    assign rx_ready_o  = (s_q.rx_stat == 8'd0);
    assign tx_valid_o  = s_q.tx_pulse;
    assign tx_data_o   = s_q.tx_data;
    assign rx_data_q_o = s_q.rx_data;
    assign rx_stat_o   = s_q.rx_stat;
    assign tx_data_q_o = s_q.tx_data;
    assign tx_stat_o   = s_q.tx_stat;

    // R7: a byte offered while ready is held, unless software overwrites the buffer
    a_r7_rx_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_valid_i && rx_ready_o &&
         !(acc_i && we_i && (sel_i == SEL_RX_DATA || sel_i == SEL_RX_STAT)))
        |=> (rx_stat_o != 8'd0 && rx_data_q_o == $past(rx_data_i)));

    // R7: a held byte is not replaced by later console traffic
    a_r7_rx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rx_ready_o && !acc_i) |=> $stable(rx_data_q_o));

    // R8: each output pulse leaves the output status at 1
    a_r8_tx_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_valid_o |-> (tx_stat_o == 8'd1));

endmodule

// File: rtl/fwg_irq.sv
module fwg_irq #(
    parameter int NUM_CPU = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_i,
    input  logic [7:0]         idx_i,
    input  logic [7:0]         level_i,
    output logic [NUM_CPU-1:0] lines_o
);

    logic [NUM_CPU-1:0] line_d, line_q;

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_line
        always_comb begin
            line_d[g] = line_q[g];
            if (wr_i && (idx_i == 8'(g))) begin
                line_d[g] = (level_i != 8'd0);
            end
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                line_q[g] <= 1'b0;
            end else begin
                line_q[g] <= line_d[g];
            end
        end
    end

    assign lines_o = line_q;

    // R5: lines hold while no interrupt write arrives
    a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_i |=> $stable(lines_o));

    // R5: a single write moves at most one line
    a_r5_one_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> $onehot0(lines_o ^ $past(lines_o)));

    // R6: an index beyond the last line changes nothing
    a_r6_out_of_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && (32'(idx_i) >= NUM_CPU)) |=> $stable(lines_o));

endmodule

// File: rtl/fw_glue_regs.sv
module fw_glue_regs
    import fwg_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int NUM_CPU   = 4,
    parameter int CPU_COUNT = 0,
    localparam int CPU_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               req_valid_i,
    input  logic               req_write_i,
    input  logic [ADDR_W-1:0]  req_addr_i,
    input  logic [2:0]         req_bytes_i,
    input  logic [DATA_W-1:0]  req_wdata_i,
    input  logic [CPU_W-1:0]   req_cpu_i,
    output logic               rsp_valid_o,
    output logic [DATA_W-1:0]  rsp_rdata_o,
    input  logic               rx_valid_i,
    input  logic [7:0]         rx_data_i,
    output logic               rx_ready_o,
    output logic               tx_valid_o,
    output logic [7:0]         tx_data_o,
    output logic [NUM_CPU-1:0] irq_o,
    output logic               halt_o,
    output logic [7:0]         exit_code_o
);

    localparam int         COUNT_EFF = (CPU_COUNT == 0) ? 1 : CPU_COUNT;
    localparam logic [7:0] COUNT_RD  = 8'(COUNT_EFF);

    typedef struct packed {
        logic              halted;
        logic [7:0]        exit_code;
        logic              rsp_valid;
        logic [DATA_W-1:0] rsp_data;
    } top_state_t;

    top_state_t st_d, st_q;
    reg_sel_e   sel;
    logic [7:0] wbyte0, wbyte1, irq_level, rbyte;
    logic [7:0] rx_data_q, rx_stat, tx_data_q, tx_stat;
    logic       irq_wr;
    logic       unused_hi;

    assign unused_hi = ^{req_addr_i[ADDR_W-1:OFS_W], req_wdata_i[DATA_W-1:16]};
    assign wbyte0    = req_wdata_i[7:0];
    assign wbyte1    = req_wdata_i[15:8];
    assign irq_level = (req_bytes_i >= 3'd2) ? wbyte1 : 8'd0;
    assign irq_wr    = req_valid_i && req_write_i && (sel == SEL_IRQ);

    fwg_decode i_decode (
        .ofs_i (req_addr_i[OFS_W-1:0]),
        .sel_o (sel)
    );

    fwg_console i_console (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .acc_i       (req_valid_i),
        .we_i        (req_write_i),
        .sel_i       (sel),
        .wbyte_i     (wbyte0),
        .rx_valid_i  (rx_valid_i),
        .rx_data_i   (rx_data_i),
        .rx_ready_o  (rx_ready_o),
        .tx_valid_o  (tx_valid_o),
        .tx_data_o   (tx_data_o),
        .rx_data_q_o (rx_data_q),
        .rx_stat_o   (rx_stat),
        .tx_data_q_o (tx_data_q),
        .tx_stat_o   (tx_stat)
    );

    fwg_irq #(.NUM_CPU(NUM_CPU)) i_irq (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (irq_wr),
        .idx_i   (wbyte0),
        .level_i (irq_level),
        .lines_o (irq_o)
    );

    always_comb begin
        case (sel)
            SEL_CPU_ID:  rbyte = 8'(req_cpu_i);
            SEL_CPU_CNT: rbyte = COUNT_RD;
            SEL_RX_DATA: rbyte = rx_data_q;
            SEL_RX_STAT: rbyte = rx_stat;
            SEL_TX_DATA: rbyte = tx_data_q;
            SEL_TX_STAT: rbyte = tx_stat;
            default:     rbyte = 8'd0;
        endcase
    end

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = req_valid_i;
        st_d.rsp_data  = '0;
        if (req_valid_i && !req_write_i) begin
            st_d.rsp_data = {{(DATA_W-8){1'b0}}, rbyte};
        end
        if (req_valid_i && req_write_i && (sel == SEL_HALT)) begin
            st_d.halted    = 1'b1;
            st_d.exit_code = wbyte0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid_o = st_q.rsp_valid;
    assign rsp_rdata_o = st_q.rsp_data;
    assign halt_o      = st_q.halted;
    assign exit_code_o = st_q.exit_code;

    // R2: the halt request is sticky
    a_r2_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        halt_o |=> halt_o);

    // R12: every request gets a response in the next cycle
    a_r12_rsp_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_i |=> rsp_valid_o);

    // R12: no response without a request one cycle earlier
    a_r12_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_valid_o |-> $past(req_valid_i));

    // R12: only the low byte of read data may be nonzero
    a_r12_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_rdata_o[DATA_W-1:8] == '0);

    // R8: an output pulse carries the byte that was written
    a_r8_tx_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_valid_o |-> ($past(req_valid_i && req_write_i) &&
                        tx_data_o == $past(req_wdata_i[7:0])));

endmodule

// File: tb/test_fw_glue_regs.sv
module test_fw_glue_regs;

    localparam int NUM_CPU = 4;
    localparam int CPU_W   = 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0, req_write = 1'b0;
    logic [31:0]        req_addr = '0, req_wdata = '0;
    logic [2:0]         req_bytes = 3'd1;
    logic [CPU_W-1:0]   req_cpu = '0;
    logic               rsp_valid;
    logic [31:0]        rsp_rdata;
    logic               rx_valid = 1'b0;
    logic [7:0]         rx_data = '0;
    logic               rx_ready, tx_valid;
    logic [7:0]         tx_data, exit_code;
    logic [NUM_CPU-1:0] irq;
    logic               halt;

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    // bench model of register state
    logic [7:0]         m_rx_data = 0, m_rx_stat = 0, m_tx_data = 0, m_tx_stat = 1;
    logic [NUM_CPU-1:0] m_irq = '0;
    logic               m_halt = 0;
    logic [7:0]         m_exit = 0;

    always #2 clk = ~clk;

    fw_glue_regs #(.NUM_CPU(NUM_CPU)) i_fw_glue_regs (
        .clk_i(clk), .rst_ni(rst_n),
        .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
        .req_bytes_i(req_bytes), .req_wdata_i(req_wdata), .req_cpu_i(req_cpu),
        .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
        .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_ready_o(rx_ready),
        .tx_valid_o(tx_valid), .tx_data_o(tx_data),
        .irq_o(irq), .halt_o(halt), .exit_code_o(exit_code)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [31:0] a, input int cpu);
        case (a[5:0])
            6'h04:   return 8'(cpu);
            6'h0C:   return 8'd1;
            6'h10:   return m_rx_data;
            6'h14:   return m_rx_stat;
            6'h18:   return m_tx_data;
            6'h1C:   return m_tx_stat;
            default: return 8'd0;
        endcase
    endfunction

    function automatic string rd_tag(input logic [31:0] a);
        if (a[31:6] != 0) return "R1 aliased read";
        case (a[5:0])
            6'h04:        return "R3 cpu id read";
            6'h0C:        return "R4 count read";
            6'h10, 6'h14: return "R7 input read";
            6'h18, 6'h1C: return "R8 output read";
            default:      return "R11 unmapped read";
        endcase
    endfunction

    task automatic op(input bit v, input bit w, input logic [31:0] a, input logic [2:0] nb,
                      input logic [31:0] wd, input int cpu, input bit rv, input logic [7:0] rd);
        logic [7:0] e_rd;
        bit         e_tx;
        logic [7:0] e_txd;
        @(negedge clk);
        req_valid = v; req_write = w; req_addr = a; req_bytes = nb;
        req_wdata = wd; req_cpu = CPU_W'(cpu); rx_valid = rv; rx_data = rd;
        #1;
        chk(rx_ready == (m_rx_stat == 0), "R7 rx_ready", 32'(rx_ready), 32'(m_rx_stat == 0));
        e_rd = (v && !w) ? exp_rd(a, cpu) : 8'd0;
        e_tx = 0;
        e_txd = m_tx_data;
        if (rv && m_rx_stat == 0) begin
            m_rx_data = rd; m_rx_stat = 1;
        end else if (v && !w && a[5:0] == 6'h10) begin
            m_rx_stat = 0;
        end
        if (v && w) begin
            case (a[5:0])
                6'h00: begin m_halt = 1; m_exit = wd[7:0]; end
                6'h08: if (wd[7:0] < NUM_CPU) m_irq[wd[7:0]] = (nb >= 2) && (wd[15:8] != 0);
                6'h10: m_rx_data = wd[7:0];
                6'h14: m_rx_stat = wd[7:0];
                6'h18: begin m_tx_data = wd[7:0]; m_tx_stat = 1; e_tx = 1; e_txd = wd[7:0]; end
                6'h1C: m_tx_stat = wd[7:0];
                default: ;
            endcase
        end
        @(posedge clk); #1;
        chk(rsp_valid == v, "R12 rsp_valid", 32'(rsp_valid), 32'(v));
        chk(rsp_rdata == 32'(e_rd), (v && !w) ? rd_tag(a) : "R12 idle data", rsp_rdata, 32'(e_rd));
        chk(tx_valid == e_tx, "R8 tx_valid", 32'(tx_valid), 32'(e_tx));
        if (e_tx) chk(tx_data == e_txd, "R8 tx_data", 32'(tx_data), 32'(e_txd));
        chk(irq == m_irq, "R5/R6 irq lines", 32'(irq), 32'(m_irq));
        chk(halt == m_halt, "R2 halt", 32'(halt), 32'(m_halt));
        chk(exit_code == m_exit, "R2 exit code", 32'(exit_code), 32'(m_exit));
    endtask

    task automatic rd(input logic [31:0] a, input int cpu);
        op(1, 0, a, 3'd4, 32'h0, cpu, 0, 8'h0);
    endtask

    task automatic wr(input logic [31:0] a, input logic [2:0] nb, input logic [31:0] wd);
        op(1, 1, a, nb, wd, 0, 0, 8'h0);
    endtask

    initial begin
        #600000;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int dummy;
        dummy = $urandom(32'd2718);
        repeat (3) @(negedge clk);
        // R9: reset values seen directly at the ports
        chk(halt == 0 && irq == 0 && rsp_valid == 0 && tx_valid == 0, "R9 reset outputs",
            {halt, irq, rsp_valid, tx_valid}, 0);
        rst_n = 1'b1;
        chk(rx_ready == 1, "R9 rx_ready after reset", 32'(rx_ready), 1);
        // R9: reset register contents
        rd(32'h10, 0); rd(32'h14, 0); rd(32'h18, 0); rd(32'h1C, 0);
        // R3, R4
        rd(32'h04, 2); rd(32'h04, 3); rd(32'h0C, 1);
        // R7: capture, full drop, consume
        op(0, 0, 0, 3'd1, 0, 0, 1, 8'h41);
        rd(32'h14, 0);
        op(0, 0, 0, 3'd1, 0, 0, 1, 8'h42);
        rd(32'h10, 0);
        rd(32'h14, 0);
        // R7: consume and a new byte in the same cycle
        op(0, 0, 0, 3'd1, 0, 0, 1, 8'h51);
        op(1, 0, 32'h10, 3'd1, 0, 0, 1, 8'h52);
        rd(32'h14, 0);
        // R8
        wr(32'h18, 3'd1, 32'hFFFF_FF5A);
        rd(32'h18, 0); rd(32'h1C, 0);
        // R10: software overwrites, including priority over a console byte
        wr(32'h1C, 3'd1, 32'h0); rd(32'h1C, 0);
        wr(32'h14, 3'd1, 32'h07); rd(32'h14, 0);
        wr(32'h14, 3'd1, 32'h00);
        op(1, 1, 32'h10, 3'd1, 32'h33, 0, 1, 8'h99);
        rd(32'h10, 0);
        // R5, R6
        wr(32'h08, 3'd2, 32'h0000_0101);
        wr(32'h08, 3'd2, 32'h0000_0503);
        wr(32'h08, 3'd1, 32'h0000_FF01);
        wr(32'h08, 3'd2, 32'h0000_0109);
        wr(32'h08, 3'd4, 32'h0000_0003);
        // R11, R1
        wr(32'h24, 3'd1, 32'hAB); rd(32'h24, 0); rd(32'h02, 0);
        rd(32'h00, 0); rd(32'h08, 0);
        wr(32'h04, 3'd1, 32'h77); wr(32'h0C, 3'd1, 32'h77);
        rd(32'h1000_0044, 1); rd(32'hFFFF_FFDC, 0);
        // R2
        wr(32'h40, 3'd1, 32'h2A);
        op(0, 0, 0, 3'd1, 0, 0, 0, 0);
        wr(32'h00, 3'd1, 32'h55);
        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [31:0] a;
            int pick;
            pick = int'($urandom % 10);
            if (pick < 8) a = ($urandom & 32'hFFFF_FFC0) | 32'(pick * 4);
            else          a = $urandom;
            op($urandom % 4 != 0, $urandom % 2 == 1, a, 3'(1 + $urandom % 4),
               $urandom & 32'hFFFF_03FF, int'($urandom % 4), $urandom % 3 == 0, 8'($urandom));
        end
        op(0, 0, 0, 3'd1, 0, 0, 0, 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule